// File: doc/BRIEF.md
# Per-Pixel Multi-Hit Timestamp Store

This block is the digital back end of a single detector pixel. While an acquisition window is open, each new hit strobe from the pixel's comparator makes the block copy the present value of the global bunch-crossing counter into a small local memory. Each stored hit therefore carries the number of the crossing in which it happened. The memory holds a fixed number of entries, kept in the order the hits arrived. Once it is full, later hits in the same window are discarded and a sticky overflow flag records the loss.

The block clears itself when a window opens, so each window starts with an empty store. Between windows, hit strobes are ignored and the contents stay frozen. A column scanner can then read the hit count and any entry it selects. The number of entries and the timestamp width are parameters.

Top module: `pixel_ts_store`

## Requirements
- R1: While reset is asserted, the hit count reads 0 and the overflow flag reads 0.
- R2: When the strobe rises at a clock edge where the window input is high and the store is not full, the counter value present at that edge is written to entry number (old count). The count output shows old count plus one after that edge.
- R3: Entries are kept in arrival order: entry 0 holds the oldest hit of the window and entry count-1 holds the newest.
- R4: A hit is recognised only on a low-to-high change of the strobe between two consecutive clock edges. A strobe that stays high records one timestamp. A strobe already high when the window opens records nothing until it goes low and rises again.
- R5: At edges where the window input is low, strobes are ignored. Count, overflow flag and all entries keep their values, and the contents stay readable.
- R6: At the first edge where the window input is high after it was low, count and overflow are cleared. A strobe rising at that same edge is stored as entry 0, so the count becomes 1.
- R7: A hit that arrives while the count equals the depth is dropped and leaves every entry unchanged. It sets the overflow flag, which stays at 1 until the next window opens or reset is asserted. Overflow is never 1 while the count is below the depth.
- R8: The entry output shows the entry picked by the select input, combinationally. The valid output is 1 exactly when the select value is below the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition window open |
| bx_count | input | TS_W | Global bunch-crossing counter |
| hit_in | input | 1 | Hit strobe from comparator |
| rd_sel | input | IDX_W | Entry select for readout |
| rd_count | output | CNT_W | Number of stored hits, 0 to DEPTH |
| rd_ts | output | TS_W | Timestamp of selected entry |
| rd_valid | output | 1 | Selected entry holds a hit of this window |
| ovf | output | 1 | Sticky overflow, hits dropped this window |

## Verification
The bench drives a strobe that stays high across many edges. A design that detects levels instead of edges would fill the store from a single hit. It also raises a strobe before the window opens, and makes a strobe rise on the exact edge where the window opens. A design that mishandles these would either record a phantom entry or wipe out a real first hit. Further cases drive more hits into a full store and strobes outside the window. These expose a design that overwrites the newest entry, lets the overflow flag fall back to 0, or keeps counting between windows. Random window and strobe patterns are checked against a model entry by entry at every select value.

// File: rtl/pix_ts_pkg.sv
package pix_ts_pkg;
  // What a detected strobe does to the store at this edge
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_STORE = 2'd1,
    ACT_DROP  = 2'd2
  } cap_act_e;
endpackage

// File: rtl/pix_hit_edge.sv
module pix_hit_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_en,
  input  logic hit_in,
  output logic hit_rise,
  output logic win_start
);
  logic hit_q, hit_d;
  logic acq_q, acq_d;

  always_comb begin
    hit_d = hit_in;
    acq_d = acq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      acq_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      acq_q <= acq_d;
    end
  end

  assign hit_rise  = hit_in & ~hit_q;
  assign win_start = acq_en & ~acq_q;
endmodule

// File: rtl/pix_ts_mem.sv
module pix_ts_mem
  import pix_ts_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TS_W  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acq_en,
  input  logic                        win_start,
  input  logic                        hit_rise,
  input  logic [TS_W-1:0]             bx_count,
  output logic [CNT_W-1:0]            count,
  output logic                        ovf,
  output logic [DEPTH-1:0][TS_W-1:0]  entries
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] base;
  logic             base_ovf;
  cap_act_e         act;
  logic [CNT_W-1:0] count_d;
  logic             ovf_d;
  logic             stat_en;
  logic [DEPTH-1:0] wr_en;

  // Window start restarts the fill point in the same cycle
  always_comb begin
    base     = win_start ? '0 : count;
    base_ovf = win_start ? 1'b0 : ovf;
    act      = ACT_NONE;
    if (acq_en && hit_rise)
      act = (base == FULL) ? ACT_DROP : ACT_STORE;
    count_d = (act == ACT_STORE) ? base + 1'b1 : base;
    ovf_d   = base_ovf | (act == ACT_DROP);
    stat_en = acq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (stat_en) begin
      count <= count_d;
      ovf   <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign wr_en[g] = (act == ACT_STORE) && (base == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entries[g] <= '0;
      else if (wr_en[g])
        entries[g] <= bx_count;
    end
  end
endmodule

// File: rtl/pix_ts_readmux.sv
module pix_ts_readmux #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][TS_W-1:0] entries,
  input  logic [CNT_W-1:0]           count,
  input  logic [IDX_W-1:0]           sel,
  output logic [TS_W-1:0]            ts,
  output logic                       valid
);
  always_comb begin
    ts = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sel == IDX_W'(i)) ts = entries[i];
  end

  assign valid = CNT_W'(sel) < count;
endmodule

// File: rtl/pixel_ts_store.sv
module pixel_ts_store #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_en,
  input  logic [TS_W-1:0]  bx_count,
  input  logic             hit_in,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_count,
  output logic [TS_W-1:0]  rd_ts,
  output logic             rd_valid,
  output logic             ovf
);
  logic                       hit_rise;
  logic                       win_start;
  logic [DEPTH-1:0][TS_W-1:0] entries;

  pix_hit_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_en    (acq_en),
    .hit_in    (hit_in),
    .hit_rise  (hit_rise),
    .win_start (win_start)
  );

  pix_ts_mem #(.DEPTH(DEPTH), .TS_W(TS_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_en    (acq_en),
    .win_start (win_start),
    .hit_rise  (hit_rise),
    .bx_count  (bx_count),
    .count     (rd_count),
    .ovf       (ovf),
    .entries   (entries)
  );

  pix_ts_readmux #(.DEPTH(DEPTH), .TS_W(TS_W)) u_rd (
    .entries (entries),
    .count   (rd_count),
    .sel     (rd_sel),
    .ts      (rd_ts),
    .valid   (rd_valid)
  );
endmodule

// File: rtl/pixel_ts_checker.sv
module pixel_ts_checker #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_en,
  input logic [CNT_W-1:0] rd_count,
  input logic             ovf
);
  // R1: reset state
  always @(posedge clk)
    if (!rst_n) a_r1_reset_empty: assert (rd_count == '0 && !ovf);

  // R5: nothing moves while the window is closed
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> ($stable(rd_count) && $stable(ovf)));

  // R2: count never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= CNT_W'(DEPTH));

  // R2: count grows by at most one per edge (or restarts low)
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |=> (rd_count <= $past(rd_count) + 1'b1 || rd_count <= CNT_W'(1)));

  // R7: overflow only with a full store
  a_r7_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> rd_count == CNT_W'(DEPTH));

  // R7: overflow sticky inside a window
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && acq_en && $past(acq_en)) |=> ovf);
endmodule

bind pixel_ts_store pixel_ts_checker #(.DEPTH(DEPTH), .TS_W(TS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acq_en   (acq_en),
  .rd_count (rd_count),
  .ovf      (ovf)
);

// File: tb/pixel_ts_store_test.sv
module pixel_ts_store_test;
  localparam int DEPTH = 4;
  localparam int TS_W  = 14;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acq_en;
  logic [TS_W-1:0]  bx_count;
  logic             hit_in;
  logic [IDX_W-1:0] rd_sel;
  logic [CNT_W-1:0] rd_count;
  logic [TS_W-1:0]  rd_ts;
  logic             rd_valid;
  logic             ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Expected state
  logic [TS_W-1:0] m_ts [DEPTH];
  int              m_cnt;
  bit              m_ovf;
  bit              m_hit_q;
  bit              m_acq_q;

  always #4 clk = ~clk;

  pixel_ts_store #(.DEPTH(DEPTH), .TS_W(TS_W)) uut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .bx_count(bx_count),
    .hit_in(hit_in), .rd_sel(rd_sel), .rd_count(rd_count), .rd_ts(rd_ts),
    .rd_valid(rd_valid), .ovf(ovf)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model of R2..R7 applied to the inputs of the edge just taken
  function automatic void model_edge(bit acq, bit hit, logic [TS_W-1:0] bx);
    bit rise = hit && !m_hit_q;
    if (acq && !m_acq_q) begin m_cnt = 0; m_ovf = 0; end
    if (acq && rise) begin
      if (m_cnt < DEPTH) begin m_ts[m_cnt] = bx; m_cnt++; end
      else m_ovf = 1;
    end
    m_hit_q = hit;
    m_acq_q = acq;
  endfunction

  task automatic check_all(string req);
    chk(req, "count", int'(rd_count), m_cnt);
    chk(req, "ovf", int'(ovf), int'(m_ovf));
    for (int i = 0; i < DEPTH; i++) begin
      rd_sel = IDX_W'(i);
      #1;
      chk("R8", "valid", int'(rd_valid), int'(i < m_cnt));
      if (i < m_cnt) chk(req, "entry", int'(rd_ts), int'(m_ts[i]));
    end
  endtask

  // One clock: inputs held across the edge, outputs checked 1 ns later
  task automatic cyc(bit acq, bit hit, string req);
    logic [TS_W-1:0] bx;
    acq_en = acq;
    hit_in = hit;
    bx = bx_count;
    @(posedge clk);
    #1;
    model_edge(acq, hit, bx);
    check_all(req);
    bx_count = bx_count + 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; acq_en = 0; hit_in = 0; rd_sel = '0; bx_count = 14'd100;
    for (int i = 0; i < DEPTH; i++) m_ts[i] = '0;
    m_cnt = 0; m_ovf = 0; m_hit_q = 0; m_acq_q = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "count", int'(rd_count), 0);
    chk("R1", "ovf", int'(ovf), 0);
    @(negedge clk);
    rst_n = 1;

    // R4: strobe high before the window opens records nothing
    cyc(0, 1, "R4");
    cyc(1, 1, "R4");
    cyc(1, 1, "R4");
    // R2/R3: three separate hits in order
    cyc(1, 0, "R2"); cyc(1, 1, "R2"); cyc(1, 0, "R3");
    cyc(1, 1, "R3"); cyc(1, 1, "R4"); cyc(1, 1, "R4");
    cyc(1, 0, "R3"); cyc(1, 1, "R3");
    // R7: fill then overflow
    cyc(1, 0, "R7"); cyc(1, 1, "R7"); cyc(1, 0, "R7"); cyc(1, 1, "R7");
    cyc(1, 0, "R7"); cyc(1, 1, "R7");
    // R5: window closed, strobes ignored, contents readable
    cyc(0, 0, "R5"); cyc(0, 1, "R5"); cyc(0, 0, "R5"); cyc(0, 1, "R5");
    cyc(0, 0, "R5");
    // R6: hit on the opening edge becomes entry 0
    cyc(1, 1, "R6");
    cyc(1, 0, "R6");
    cyc(0, 0, "R6");

    // Random windows and strobes
    for (int k = 0; k < 3000; k++) begin
      bit a = ($urandom % 16) != 0 ? m_acq_q : !m_acq_q;
      bit h = ($urandom % 3) == 0;
      cyc(a, h, "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule